// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation analog-to-digital converter. Software programs it through a small byte-wide register port. It drives the analog channel select and the reference select to the analog side. While a conversion runs it presents a trial code to the DAC and reads back a one-bit comparator decision. It derives a conversion clock period (TAD) from the system clock, enforces a sampling interval before the approximation begins and resolves one bit per TAD, most significant bit first. When the conversion ends it stores the code in a pair of result registers and raises an interrupt flag.

A conversion is requested by setting a start bit, which then reads back as a busy flag until the conversion is over. Clearing that bit while the approximation is running stops it and keeps the bits decided so far. A single write that both switches the block on and requests a conversion is treated as a configuration error: the request is dropped.

Top module: `sar_seq`

## Requirements
- R1: After reset all four registers read 0, `irq` is low and `dac_code` is 0.
- R2: Address 0 is the control register: bit 0 enable, bit 1 start/busy, bits 5:2 channel, bits 7:6 divider select. Address 1 is the config register: bits 2:0 reference select, bit 3 right-justify, bit 4 interrupt enable, bit 5 interrupt flag. Addresses 2 and 3 are the high and low result bytes. `chan_sel` and `ref_sel` follow their fields.
- R3: One TAD lasts 2, 8, 32 or 64 system clocks for divider select 0, 1, 2 or 3. During a conversion `dac_code` changes once per TAD.
- R4: The approximation cannot begin until 3 whole TADs have passed since the block was enabled or the channel field last changed. A start made earlier waits for that interval.
- R5: Writing 1 to the start bit while enabled sets busy. The 13-TAD conversion phase follows, and busy then clears by itself.
- R6: Each step sets the next trial bit from MSB to LSB on `dac_code`. The bit is kept when `cmp_in` is 1 (input at or above the trial code) and cleared otherwise. The final result equals the ideal code of the input.
- R7: With right-justify set, the high byte is {4'b0, code[11:8]} and the low byte is code[7:0]. With it clear, the high byte is code[11:4] and the low byte is {code[3:0], 4'b0}.
- R8: Completion sets the flag. The flag stays set until software writes 0 to config bit 5, and writing 1 there does not set it. `irq` is high only while both the flag and the interrupt enable are 1.
- R9: Writing 0 to the start bit during the approximation aborts it. The result then holds the bits decided so far, with the undecided bits 0. Busy clears and the flag is not set.
- R10: A control write that sets both enable and start while the block is disabled enables it but drops the start: busy stays 0 and no conversion runs.
- R11: A start written while enable is 0 has no effect and reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| chan_sel | output | 4 | Analog channel select |
| ref_sel | output | 3 | Voltage reference select |
| dac_code | output | 12 | Trial code while converting, else 0 |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check these properties:
- TAD strobes are never adjacent.
- The sampling counter, once satisfied, stays satisfied until a restart.
- The approximation starts only after the sampling interval.
- Busy never outlives enable.
- Completion sets the flag and clears busy.
- An abort copies the decided bits.
- A combined enable-and-start write never yields busy.

Only the bench scenarios can show that the final codes match an ideal comparator model for each divider and justification. They also show that the TAD length and the total conversion time are correct, and that aborts at chosen steps leave the expected partial codes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  localparam int RES_W_DEF = 12;
  localparam int DIV_CNT_W = 7;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CFG  = 2'd1,
    RA_HIGH = 2'd2,
    RA_LOW  = 2'd3
  } reg_addr_e;

  // Number of system clocks in one TAD for a divider select value.
  function automatic logic [DIV_CNT_W-1:0] tad_ratio(input logic [1:0] sel);
    case (sel)
      2'd0:    return DIV_CNT_W'(2);
      2'd1:    return DIV_CNT_W'(8);
      2'd2:    return DIV_CNT_W'(32);
      default: return DIV_CNT_W'(64);
    endcase
  endfunction

endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen
  import sar_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [DIV_CNT_W-1:0] ratio,
  output logic                 tick
);
  logic [DIV_CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= ratio - DIV_CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_CNT_W'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3

endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
  parameter int ACQ_TADS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic acq_ok
);
  localparam int AW = $clog2(ACQ_TADS + 1);
  localparam logic [AW-1:0] FULL = AW'(ACQ_TADS);

  logic [AW-1:0] cnt_q;

  assign acq_ok = (cnt_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || restart)   cnt_q <= '0;
    else if (tick && !acq_ok)   cnt_q <= cnt_q + AW'(1);
  end

  AST_ACQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_ok && run && !restart) |=> acq_ok); // R4

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go,
  input  logic             abort,
  input  logic             cmp,
  output logic             active,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] acc,
  output logic             done
);
  localparam int SW = $clog2(RES_W + 1);
  localparam logic [SW-1:0] LAST = SW'(RES_W);

  logic [SW-1:0]    step_q;
  logic [RES_W-1:0] cur_q;

  assign trial = acc | cur_q;
  assign done  = active && tick && !abort && (step_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step_q <= '0;
      cur_q  <= '0;
      acc    <= '0;
    end else if (abort) begin
      active <= 1'b0;
      cur_q  <= '0;
    end else if (go) begin
      active <= 1'b1;
      step_q <= '0;
      acc    <= '0;
      cur_q  <= {1'b1, {(RES_W-1){1'b0}}};
    end else if (active && tick) begin
      if (step_q == LAST) begin
        active <= 1'b0;
      end else begin
        if (cmp) acc <= acc | cur_q;
        cur_q  <= cur_q >> 1;
        step_q <= step_q + SW'(1);
      end
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (step_q <= LAST)); // R6
  AST_ONE_TRIAL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> $onehot0(cur_q)); // R6

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W    = RES_W_DEF,
  parameter int ACQ_TADS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic [3:0]       chan_sel,
  output logic [2:0]       ref_sel,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_in,
  output logic             irq
);
  // Place the code in a 16-bit result pair, left or right justified.
  function automatic logic [15:0] place(input logic [RES_W-1:0] c, input logic right);
    logic [15:0] w;
    w = 16'(c);
    return right ? w : (w << (16 - RES_W));
  endfunction

  // control and config state
  logic             en_q, busy_q, rjust_q, ie_q, flag_q;
  logic [1:0]       div_q;
  logic [3:0]       chan_q;
  logic [2:0]       ref_q;
  logic [RES_W-1:0] res_q;

  // named internal events
  logic ctrl_wr, cfg_wr, en_rise_wr, start_accept, abort_evt, acq_restart;
  logic tick, acq_ok, conv_active, conv_done, conv_go;
  logic [RES_W-1:0] trial_w, acc_w;
  logic [15:0] placed;
  logic unused_ok;

  assign ctrl_wr      = reg_we && (reg_addr == RA_CTRL);
  assign cfg_wr       = reg_we && (reg_addr == RA_CFG);
  assign en_rise_wr   = ctrl_wr && reg_wdata[0] && !en_q;
  assign start_accept = ctrl_wr && reg_wdata[0] && reg_wdata[1] && en_q && !busy_q;
  assign abort_evt    = ctrl_wr && busy_q && (!reg_wdata[1] || !reg_wdata[0]);
  assign acq_restart  = en_rise_wr || (ctrl_wr && (reg_wdata[5:2] != chan_q));
  assign conv_go      = busy_q && !conv_active && acq_ok && tick && !abort_evt;
  assign unused_ok    = &{1'b0, reg_wdata[7:6] & {2{cfg_wr}}};

  sar_tad_gen u_tad (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .ratio (tad_ratio(div_q)),
    .tick  (tick)
  );

  sar_acq_timer #(.ACQ_TADS(ACQ_TADS)) u_acq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .restart (acq_restart),
    .tick    (tick),
    .acq_ok  (acq_ok)
  );

  sar_engine #(.RES_W(RES_W)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .go     (conv_go),
    .abort  (abort_evt),
    .cmp    (cmp_in),
    .active (conv_active),
    .trial  (trial_w),
    .acc    (acc_w),
    .done   (conv_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      chan_q <= '0;
      ref_q  <= '0;
      rjust_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= reg_wdata[0];
        chan_q <= reg_wdata[5:2];
        div_q  <= reg_wdata[7:6];
      end
      if (cfg_wr) begin
        ref_q   <= reg_wdata[2:0];
        rjust_q <= reg_wdata[3];
        ie_q    <= reg_wdata[4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            busy_q <= 1'b0;
    else if (abort_evt)    busy_q <= 1'b0;
    else if (conv_done)    busy_q <= 1'b0;
    else if (start_accept) busy_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          res_q <= '0;
    else if (conv_done)                  res_q <= acc_w;
    else if (abort_evt && conv_active)   res_q <= acc_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         flag_q <= 1'b0;
    else if (conv_done)                 flag_q <= 1'b1;
    else if (cfg_wr && !reg_wdata[5])   flag_q <= 1'b0;
  end

  assign placed = place(res_q, rjust_q);

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {div_q, chan_q, busy_q, en_q};
      RA_CFG:  reg_rdata = {2'b00, flag_q, ie_q, rjust_q, ref_q};
      RA_HIGH: reg_rdata = placed[15:8];
      default: reg_rdata = placed[7:0];
    endcase
  end

  assign chan_sel = chan_q;
  assign ref_sel  = ref_q;
  assign dac_code = conv_active ? trial_w : '0;
  assign irq      = flag_q && ie_q;

  AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> en_q); // R11
  AST_CONV_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_active) |-> $past(acq_ok)); // R4
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (flag_q && !busy_q)); // R8
  AST_ABORT_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && conv_active) |=> (res_q == $past(acc_w) && !busy_q)); // R9
  AST_JOINT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[1:0] == 2'b11 && !en_q) |=> !busy_q); // R10

endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [3:0]  chan_sel;
  logic [2:0]  ref_sel;
  logic [11:0] dac_code;
  logic        cmp_in;
  logic        irq;
  logic [11:0] vin = 12'd0;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // ideal comparator
  assign cmp_in = (vin >= dac_code);

  sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_sel(chan_sel),
    .ref_sel(ref_sel), .dac_code(dac_code), .cmp_in(cmp_in), .irq(irq)
  );

  // vector: {chan[3:0], vin[11:0], div[1:0], right_just}
  localparam logic [18:0] VEC [6] = '{
    {4'd1,  12'hABC, 2'd0, 1'b1},
    {4'd2,  12'h000, 2'd1, 1'b0},
    {4'd5,  12'hFFF, 2'd0, 1'b1},
    {4'd9,  12'h801, 2'd2, 1'b0},
    {4'd15, 12'h7FF, 2'd0, 1'b0},
    {4'd0,  12'h123, 2'd3, 1'b1}
  };

  function automatic int tad_len(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : (s == 2'd2) ? 32 : 64;
  endfunction

  // binary search against the analog value
  function automatic logic [11:0] ideal(input logic [11:0] v);
    logic [11:0] c = '0;
    for (int b = 11; b >= 0; b--) begin
      if ({1'b0, v} >= {1'b0, c | (12'd1 << b)}) c = c | (12'd1 << b);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] d;
    cyc = 0;
    rd(2'd0, d);
    while (d[1] && cyc < 5000) begin
      @(negedge clk); cyc++; rd(2'd0, d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, hi, lo;
    int cyc, c0;
    logic [11:0] prev, code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk(d == 8'd0, "R1 reg reset", d, 0);
    end
    chk(irq == 1'b0 && dac_code == 12'd0, "R1 outputs reset", {irq, dac_code}, 0);

    // R11 start while disabled
    wr(2'd0, 8'h02);
    repeat (40) @(negedge clk);
    rd(2'd0, d);
    chk(d == 8'h00, "R11 start ignored when disabled", d, 0);
    chk(dac_code == 12'd0, "R11 no conversion", dac_code, 0);

    // R10 enable and start together
    wr(2'd0, 8'h03);
    rd(2'd0, d);
    chk(d == 8'h01, "R10 start dropped", d, 8'h01);
    repeat (60) @(negedge clk);
    rd(2'd0, d);
    chk(d[1] == 1'b0 && dac_code == 12'd0, "R10 no conversion ran", {d[1], dac_code}, 0);

    // vector table: R2 R3 R5 R6 R7 R8
    foreach (VEC[i]) begin
      logic [3:0] ch = VEC[i][18:15];
      logic [1:0] dv = VEC[i][2:1];
      logic       rj = VEC[i][0];
      logic [11:0] exp_code;
      vin = VEC[i][14:3];
      exp_code = ideal(vin);
      wr(2'd1, {2'b00, 1'b0, 1'b1, rj, 3'(i)});
      wr(2'd0, {dv, ch, 1'b0, 1'b1});
      rd(2'd0, d);
      chk(d == {dv, ch, 2'b01}, "R2 ctrl readback", d, {dv, ch, 2'b01});
      chk(chan_sel == ch && ref_sel == 3'(i), "R2 select outputs", {chan_sel, ref_sel}, {ch, 3'(i)});
      wr(2'd0, {dv, ch, 1'b1, 1'b1});
      cyc = 0;
      while (dac_code == 12'd0 && cyc < 2000) begin @(negedge clk); cyc++; end
      prev = dac_code; c0 = 0;
      while (dac_code == prev && c0 < 2000) begin @(negedge clk); c0++; end
      chk(c0 == tad_len(dv), "R3 TAD length", c0, tad_len(dv));
      wait_idle(cyc);
      rd(2'd2, hi); rd(2'd3, lo);
      if (rj) chk({hi, lo} == {4'd0, exp_code}, "R6 R7 right result", {hi, lo}, {4'd0, exp_code});
      else    chk({hi, lo} == {exp_code, 4'd0}, "R6 R7 left result", {hi, lo}, {exp_code, 4'd0});
      chk(irq == 1'b1, "R8 irq after done", irq, 1);
    end

    // R8 flag write semantics
    wr(2'd1, 8'h38);
    rd(2'd1, d);
    chk(d[5] == 1'b1, "R8 write 1 keeps flag", d[5], 1);
    wr(2'd1, 8'h08);
    rd(2'd1, d);
    chk(d[5] == 1'b0 && irq == 1'b0, "R8 flag cleared", {d[5], irq}, 0);

    // R5 conversion time with sampling already satisfied, TAD = 8
    vin = 12'h5A5;
    wr(2'd0, {2'd1, 4'd3, 1'b0, 1'b1});
    repeat (100) @(negedge clk);
    wr(2'd0, {2'd1, 4'd3, 1'b1, 1'b1});
    wait_idle(cyc);
    chk(cyc >= 13*8 && cyc <= 14*8 + 2, "R5 conversion duration", cyc, 13*8);
    rd(2'd3, lo); rd(2'd2, hi);
    chk({hi, lo} == {4'd0, ideal(12'h5A5)}, "R5 result", {hi, lo}, ideal(12'h5A5));
    rd(2'd1, d);
    chk(d[5] == 1'b1 && irq == 1'b0, "R8 flag set, irq masked", {d[5], irq}, 2'b10);
    wr(2'd1, 8'h18);

    // R4 sampling interval after enable
    wr(2'd0, 8'h00);
    wr(2'd0, {2'd1, 4'd3, 1'b0, 1'b1});
    wr(2'd0, {2'd1, 4'd3, 1'b1, 1'b1});
    cyc = 1;
    while (dac_code == 12'd0 && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(cyc > 3*8, "R4 waits 3 TAD after enable", cyc, 3*8 + 1);
    wait_idle(cyc);
    // R4 sampling interval after a channel change
    wr(2'd0, {2'd1, 4'd7, 1'b0, 1'b1});
    wr(2'd0, {2'd1, 4'd7, 1'b1, 1'b1});
    cyc = 1;
    while (dac_code == 12'd0 && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(cyc > 3*8 - 8, "R4 waits after channel change", cyc, 3*8);
    wait_idle(cyc);
    wr(2'd1, 8'h18);

    // R9 aborts at chosen steps, TAD = 64
    vin = 12'hA5D;
    wr(2'd0, {2'd3, 4'd7, 1'b0, 1'b1});
    repeat (300) @(negedge clk);
    foreach (VEC[j]) begin
      int k;
      logic [11:0] mask, bitk;
      if (j > 3) continue;
      k = (j == 0) ? 0 : (j == 1) ? 3 : (j == 2) ? 7 : 11;
      mask = 12'((13'd1 << (12 - k)) - 13'd1);
      bitk = 12'd1 << (11 - k);
      wr(2'd0, {2'd3, 4'd7, 1'b1, 1'b1});
      cyc = 0;
      while ((dac_code & mask) != bitk && cyc < 5000) begin @(negedge clk); cyc++; end
      wr(2'd0, {2'd3, 4'd7, 1'b0, 1'b1});
      code = ideal(vin) & ~mask;
      rd(2'd2, hi); rd(2'd3, lo);
      chk({hi, lo} == {4'd0, code}, "R9 partial code", {hi, lo}, code);
      rd(2'd1, d); lo = d;
      rd(2'd0, d);
      chk(d[1] == 1'b0 && lo[5] == 1'b0, "R9 busy clear, no flag", {d[1], lo[5]}, 0);
      repeat (20) @(negedge clk);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule